// File: doc/BRIEF.md
# LDPC Syndrome Checker for a Shortened Rate-7/8 Quasi-Cyclic Code

This block takes a received, hard-decided, shortened codeword one bit per beat and computes its 1022-bit parity-check syndrome. The parity-check matrix is a 2 x 16 array of 511 x 511 circulants. Each circulant has two ones per row. The received frame is 8160 bits long. Its first 8158 bits are codeword columns 18 through 8175. Its final two bits are transmitted zero fill, which the block accepts and throws away. The 18 leading virtual zeros of the unshortened 8176-column codeword are never received. They are accounted for by starting the column count at 18, because a zero column toggles nothing.

Each payload bit equal to one flips four syndrome bits, two in each row block, chosen from a constant table of first-row one positions. At the end of the frame the block pulses `done` for one cycle, presents the syndrome and raises `ok` when the syndrome is all zero. A synchronous `start` arms the block for the next frame.

The input is a valid/ready stream. A beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. The source may insert idle cycles at any time. `in_ready` is high from the cycle after `start` until the final beat of the frame transfers. It is low in every other cycle, so the sink never stalls the source in the middle of a frame. A source holding `in_valid` high while `in_ready` is low transfers nothing.

Top module: `ldpc_syndrome_check`

## Requirements
- R1: After reset, `in_ready`, `done` and `ok` are low and `syndrome` is all zero.
- R2: A `start` high on a clock edge clears the syndrome and the frame position, and `in_ready` is high in the next cycle. A `start` in the middle of a frame discards the partial frame.
- R3: A beat transfers only on an edge with `in_valid` and `in_ready` both high. Idle cycles inside a frame do not change the result.
- R4: The first received bit of a frame is codeword column 18, which is block 0, offset 18. Columns 0 to 17 are treated as zero. A first bit of one therefore sets exactly syndrome bits 18, 353, 569 and 941.
- R5: A one at column c = 511*j + t toggles syndrome bit i*511 + ((t - p) mod 511) for row block i in {0,1} and for each of the two first-row positions p of circulant (i, j). The table is: block 0 = {0,176} {12,239} {0,352} {24,431} {0,392} {151,409} {0,351} {9,359} {0,307} {53,329} {0,207} {18,281} {0,399} {202,457} {0,247} {36,261}; block 1 = {99,471} {130,473} {198,435} {260,478} {215,420} {282,481} {48,396} {193,445} {273,430} {302,451} {96,379} {191,386} {244,467} {364,470} {51,382} {192,414}. A zero bit toggles nothing.
- R6: The last two beats of the 8160-beat frame are fill. Their values have no effect on the syndrome.
- R7: `done` is high for exactly one cycle, the cycle after the 8160th beat transfers. At that point `syndrome` holds the full result, and it stays held until the next `start`.
- R8: `ok` is high exactly when `done` is high and all 1022 syndrome bits are zero.
- R9: Between `done` (or reset) and the next `start`, `in_ready` is low and beats offered on `in_valid` leave the syndrome unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous frame arm and clear |
| in_valid | input | 1 | Source has a received bit |
| in_ready | output | 1 | Block accepts a bit this cycle |
| in_bit | input | 1 | Hard-decision received bit |
| done | output | 1 | One-cycle end-of-frame pulse |
| ok | output | 1 | Syndrome all zero, valid with `done` |
| syndrome | output | 1022 | Syndrome; bit i*511+r is row r of row block i |

## Verification
An all-zero payload with ones in the fill positions must give a zero syndrome and `ok`. This separates correct fill discarding from fill being folded into the checks. A single one at the first received position and a single one at the last column pin down the virtual-fill offset and the modular row wrap at both ends of the matrix. Random payloads, sent with random idle gaps and also sent back to back, are compared against a bench model of the column-to-row rule. These runs expose table, block-select or handshake errors. A restart in the middle of a frame, and beats offered after `done`, show whether `start` truly clears the block and whether the idle state ignores input.

// File: rtl/ldpc_chk_pkg.sv
package ldpc_chk_pkg;
  localparam int CIRC     = 511;
  localparam int ROW_BLKS = 2;
  localparam int COL_BLKS = 16;
  localparam int WEIGHT   = 2;
  localparam int VFILL    = 18;
  localparam int TFILL    = 2;
  localparam int OFF_W    = $clog2(CIRC);

  typedef logic [OFF_W-1:0] off_t;

  // first-row one positions of each circulant, [row block][column block][k]
  localparam off_t FIRST_POS [ROW_BLKS][COL_BLKS][WEIGHT] = '{
    '{ '{0,176}, '{12,239}, '{0,352}, '{24,431}, '{0,392}, '{151,409},
       '{0,351}, '{9,359}, '{0,307}, '{53,329}, '{0,207}, '{18,281},
       '{0,399}, '{202,457}, '{0,247}, '{36,261} },
    '{ '{99,471}, '{130,473}, '{198,435}, '{260,478}, '{215,420}, '{282,481},
       '{48,396}, '{193,445}, '{273,430}, '{302,451}, '{96,379}, '{191,386},
       '{244,467}, '{364,470}, '{51,382}, '{192,414} }
  };
endpackage

// File: rtl/ldpc_frame_tracker.sv
module ldpc_frame_tracker #(
  parameter int CIRC     = ldpc_chk_pkg::CIRC,
  parameter int COL_BLKS = ldpc_chk_pkg::COL_BLKS,
  parameter int VFILL    = ldpc_chk_pkg::VFILL,
  parameter int TFILL    = ldpc_chk_pkg::TFILL,
  localparam int OFF_W   = $clog2(CIRC),
  localparam int BLK_W   = $clog2(COL_BLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             col_en,
  output logic [BLK_W-1:0] blk,
  output logic [OFF_W-1:0] off,
  output logic             done
);
  localparam int NCOL      = CIRC * COL_BLKS;
  localparam int PAYLOAD   = NCOL - VFILL;
  localparam int RX_BITS   = PAYLOAD + TFILL;
  localparam int CNT_W     = $clog2(RX_BITS);
  localparam int START_BLK = VFILL / CIRC;
  localparam int START_OFF = VFILL % CIRC;

  logic             active_q, done_q, beat;
  logic [CNT_W-1:0] rx_q;
  logic [BLK_W-1:0] blk_q;
  logic [OFF_W-1:0] off_q;

  assign beat     = in_valid & active_q;
  assign col_en   = beat & (rx_q < CNT_W'(PAYLOAD));
  assign in_ready = active_q;
  assign blk      = blk_q;
  assign off      = off_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      rx_q     <= '0;
      blk_q    <= '0;
      off_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        rx_q     <= '0;
        blk_q    <= BLK_W'(START_BLK);
        off_q    <= OFF_W'(START_OFF);
      end else if (beat) begin
        rx_q <= rx_q + 1'b1;
        if (col_en) begin
          if (off_q == OFF_W'(CIRC - 1)) begin
            off_q <= '0;
            blk_q <= blk_q + 1'b1;
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        if (rx_q == CNT_W'(RX_BITS - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !$past(start)) |-> !active_q); // R9
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active_q && rx_q == '0)); // R2
  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < OFF_W'(CIRC)); // R5
endmodule

// File: rtl/ldpc_row_map.sv
module ldpc_row_map #(
  parameter int CIRC     = ldpc_chk_pkg::CIRC,
  parameter int COL_BLKS = ldpc_chk_pkg::COL_BLKS,
  parameter int ROW_BLKS = ldpc_chk_pkg::ROW_BLKS,
  parameter int WEIGHT   = ldpc_chk_pkg::WEIGHT,
  localparam int OFF_W   = $clog2(CIRC),
  localparam int BLK_W   = $clog2(COL_BLKS)
) (
  input  logic [BLK_W-1:0]                   blk,
  input  logic [OFF_W-1:0]                   off,
  output logic [ROW_BLKS*WEIGHT*OFF_W-1:0]   rows
);
  for (genvar rb = 0; rb < ROW_BLKS; rb++) begin : g_rb
    for (genvar w = 0; w < WEIGHT; w++) begin : g_w
      localparam int SLOT = (rb * WEIGHT + w) * OFF_W;
      logic [OFF_W-1:0] pos;
      logic [OFF_W:0]   diff;
      always_comb begin
        pos = ldpc_chk_pkg::FIRST_POS[rb][blk][w];
        if (off >= pos) diff = {1'b0, off} - {1'b0, pos};
        else            diff = {1'b0, off} + (OFF_W+1)'(CIRC) - {1'b0, pos};
      end
      assign rows[SLOT +: OFF_W] = diff[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/ldpc_syn_accum.sv
module ldpc_syn_accum #(
  parameter int CIRC     = ldpc_chk_pkg::CIRC,
  parameter int ROW_BLKS = ldpc_chk_pkg::ROW_BLKS,
  parameter int WEIGHT   = ldpc_chk_pkg::WEIGHT,
  localparam int OFF_W   = $clog2(CIRC),
  localparam int NROW    = ROW_BLKS * CIRC
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             en,
  input  logic                             bit_in,
  input  logic [ROW_BLKS*WEIGHT*OFF_W-1:0] rows,
  output logic [NROW-1:0]                  syn
);
  logic [NROW-1:0] syn_q, mask;

  always_comb begin
    mask = '0;
    for (int rb = 0; rb < ROW_BLKS; rb++) begin
      for (int w = 0; w < WEIGHT; w++) begin
        mask[rb*CIRC + int'(rows[(rb*WEIGHT+w)*OFF_W +: OFF_W])] ^= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             syn_q <= '0;
    else if (clr)           syn_q <= '0;
    else if (en && bit_in)  syn_q <= syn_q ^ mask;
  end

  assign syn = syn_q;

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (syn_q == '0)); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(syn_q)); // R9
  AST_ZERO_BIT_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && !bit_in) |=> $stable(syn_q)); // R5
  AST_EVEN_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(syn_q) % 2) == 0); // R5

  for (genvar k = 0; k < ROW_BLKS*WEIGHT; k++) begin : g_chk
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (rows[k*OFF_W +: OFF_W] < OFF_W'(CIRC))); // R5
  end
endmodule

// File: rtl/ldpc_syndrome_check.sv
module ldpc_syndrome_check #(
  parameter int CIRC     = ldpc_chk_pkg::CIRC,
  parameter int COL_BLKS = ldpc_chk_pkg::COL_BLKS,
  parameter int ROW_BLKS = ldpc_chk_pkg::ROW_BLKS,
  parameter int WEIGHT   = ldpc_chk_pkg::WEIGHT,
  parameter int VFILL    = ldpc_chk_pkg::VFILL,
  parameter int TFILL    = ldpc_chk_pkg::TFILL,
  localparam int NROW    = ROW_BLKS * CIRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  output logic            done,
  output logic            ok,
  output logic [NROW-1:0] syndrome
);
  localparam int OFF_W = $clog2(CIRC);
  localparam int BLK_W = $clog2(COL_BLKS);

  logic                             col_en;
  logic [BLK_W-1:0]                 blk;
  logic [OFF_W-1:0]                 off;
  logic [ROW_BLKS*WEIGHT*OFF_W-1:0] rows;

  ldpc_frame_tracker #(
    .CIRC(CIRC), .COL_BLKS(COL_BLKS), .VFILL(VFILL), .TFILL(TFILL)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .col_en(col_en), .blk(blk), .off(off), .done(done)
  );

  ldpc_row_map #(
    .CIRC(CIRC), .COL_BLKS(COL_BLKS), .ROW_BLKS(ROW_BLKS), .WEIGHT(WEIGHT)
  ) u_map (
    .blk(blk), .off(off), .rows(rows)
  );

  ldpc_syn_accum #(
    .CIRC(CIRC), .ROW_BLKS(ROW_BLKS), .WEIGHT(WEIGHT)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(col_en), .bit_in(in_bit),
    .rows(rows), .syn(syndrome)
  );

  assign ok = done & ~|syndrome;

  AST_OK_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (done && syndrome == '0)); // R8
endmodule

// File: tb/ldpc_syndrome_check_bench.sv
module ldpc_syndrome_check_bench;
  localparam int NROW = 1022;
  localparam int RXN  = 8160;
  localparam int PAY  = 8158;

  localparam int TB_POS [2][16][2] = '{
    '{ '{0,176}, '{12,239}, '{0,352}, '{24,431}, '{0,392}, '{151,409},
       '{0,351}, '{9,359}, '{0,307}, '{53,329}, '{0,207}, '{18,281},
       '{0,399}, '{202,457}, '{0,247}, '{36,261} },
    '{ '{99,471}, '{130,473}, '{198,435}, '{260,478}, '{215,420}, '{282,481},
       '{48,396}, '{193,445}, '{273,430}, '{302,451}, '{96,379}, '{191,386},
       '{244,467}, '{364,470}, '{51,382}, '{192,414} }
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, done, ok;
  logic [NROW-1:0] syndrome;
  logic [NROW-1:0] exp_syn;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ldpc_syndrome_check u_ldpc_syndrome_check (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .done(done), .ok(ok),
    .syndrome(syndrome)
  );

  task automatic chk(input bit pass, input string msg);
    checks++;
    if (!pass) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic model_toggle(input int col);
    int j = col / 511;
    int t = col % 511;
    for (int rb = 0; rb < 2; rb++)
      for (int w = 0; w < 2; w++)
        exp_syn[rb*511 + ((t - TB_POS[rb][j][w] + 511) % 511)] ^= 1'b1;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1; exp_syn = '0;
    @(negedge clk); start = 1'b0;
    chk(in_ready === 1'b1, $sformatf("R2 in_ready after start act=%b exp=1", in_ready));
    chk(syndrome === '0, $sformatf("R2 syndrome cleared act=%0d ones exp=0", $countones(syndrome)));
  endtask

  // mode 0: zeros + fill ones, 1: random, 2: single one at column sel, 3: random no gaps
  task automatic send_frame(input int mode, input int sel, input int nbeats);
    for (int rx = 0; rx < nbeats; rx++) begin
      bit b;
      case (mode)
        0: b = (rx >= PAY);
        1, 3: b = 1'($urandom_range(0, 1));
        default: b = (rx + 18 == sel);
      endcase
      if (mode == 1) begin
        while ($urandom_range(0, 99) < 30) begin
          @(negedge clk); in_valid = 1'b0;
          chk(in_ready === 1'b1, $sformatf("R3 ready in gap act=%b exp=1", in_ready));
        end
      end
      @(negedge clk);
      if (rx == RXN - 1)
        chk(done === 1'b0, $sformatf("R7 done early act=%b exp=0", done));
      in_valid = 1'b1; in_bit = b;
      if (b && rx < PAY) model_toggle(rx + 18);
      @(posedge clk);
    end
    @(negedge clk); in_valid = 1'b0; in_bit = 1'b0;
  endtask

  task automatic check_end(input string tag);
    chk(done === 1'b1, $sformatf("R7 %s done act=%b exp=1", tag, done));
    chk(syndrome === exp_syn, $sformatf("R5 %s syndrome act=%h exp=%h", tag, syndrome, exp_syn));
    chk(ok === (exp_syn == '0), $sformatf("R8 %s ok act=%b exp=%b", tag, ok, exp_syn == '0));
    chk(in_ready === 1'b0, $sformatf("R9 %s ready after frame act=%b exp=0", tag, in_ready));
    @(negedge clk);
    chk(done === 1'b0, $sformatf("R7 %s done width act=%b exp=0", tag, done));
    chk(ok === 1'b0, $sformatf("R8 %s ok drops act=%b exp=0", tag, ok));
    chk(syndrome === exp_syn, $sformatf("R7 %s syndrome held act=%h exp=%h", tag, syndrome, exp_syn));
  endtask

  task automatic offer_idle(input string tag);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); in_valid = 1'b1; in_bit = 1'b1;
      chk(in_ready === 1'b0, $sformatf("R9 %s ready while idle act=%b exp=0", tag, in_ready));
    end
    @(negedge clk); in_valid = 1'b0; in_bit = 1'b0;
    chk(syndrome === exp_syn, $sformatf("R9 %s idle beats ignored act=%h exp=%h", tag, syndrome, exp_syn));
    chk(done === 1'b0, $sformatf("R9 %s no done while idle act=%b exp=0", tag, done));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    exp_syn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b0, $sformatf("R1 in_ready act=%b exp=0", in_ready));
    chk(done === 1'b0, $sformatf("R1 done act=%b exp=0", done));
    chk(ok === 1'b0, $sformatf("R1 ok act=%b exp=0", ok));
    chk(syndrome === '0, $sformatf("R1 syndrome act=%0d ones exp=0", $countones(syndrome)));
    offer_idle("before first start");

    // R6: zero payload, fill bits set
    do_start(); send_frame(0, 0, RXN); check_end("zero+fill");

    // R4: single one at first received bit, hand-computed rows
    do_start(); send_frame(2, 18, RXN);
    chk(syndrome[18] && syndrome[353] && syndrome[569] && syndrome[941] &&
        $countones(syndrome) == 4,
        $sformatf("R4 first bit rows act=%h exp=bits 18,353,569,941", syndrome));
    check_end("first-bit");

    // R5: single one at last column 8175 (block 15, offset 510)
    do_start(); send_frame(2, 8175, RXN); check_end("last-col");
    offer_idle("after done");

    // R3: random payload with idle gaps
    do_start(); send_frame(1, 0, RXN); check_end("random-gaps");

    // R5: random payload back to back
    do_start(); send_frame(3, 0, RXN); check_end("random-dense");

    // R2: restart mid-frame then clean frame
    do_start(); send_frame(3, 0, 1000);
    do_start(); send_frame(0, 0, RXN); check_end("restart");

    finish_run();
  end
endmodule